// File: doc/BRIEF.md
# Outgoing Serial Word Queue with Status Flags

This block buffers 32-bit words on their way to an avionics serial transmitter. A command decoder upstream pushes one word per write pulse. The serializer downstream reads the oldest word from a combinational head port and pops it when it has taken the word. Up to 32 words are held.

The queue keeps a registered occupancy count beside its read and write pointers. From these it derives three status bits: empty, half-full and full. It also drives one interrupt flag, and a configuration input selects whether that flag follows the empty bit or the full bit. The empty bit does not assert while the serializer still reports that it is sending the last word it popped. A synchronous clear command and a master-reset pulse both discard the contents. The master reset also forces every flag low for one cycle.

The half-full bit lets a host start a 16-word block write whenever the bit reads 0, with no risk of overflow.

Top module: `txq_fifo`

## Requirements
- R1: Words leave in the order they were accepted. `head_o` shows the oldest stored word combinationally. An accepted pop (`pop_i` high with at least one word stored) moves `head_o` to the next word at the following rising clock edge.
- R2: With 32 words stored, a write is dropped. Neither the contents nor the occupancy change, and the queue keeps dropping writes until a pop frees a position.
- R3: `half_o` is 1 exactly when 16 or more words are stored, and 0 when fewer than 16 are stored.
- R4: `empty_o` is 1 only when no word is stored and `ser_busy_i` was low at the last clock edge. While `ser_busy_i` is high, `empty_o` stays 0 even with nothing stored.
- R5: `flag_o` equals `empty_o` when `irq_sel_i` was 0 at the last edge, and equals `full_o` when it was 1.
- R6: `clear_i` high at a clock edge discards all stored words. After that edge `avail_o` is 0, and the next accepted write appears on `head_o`.
- R7: `mreset_i` high at a clock edge discards all stored words and forces `empty_o`, `half_o`, `full_o` and `flag_o` to 0 after that edge. From the next edge on, the flags again follow the occupancy. `mreset_i` takes priority over `clear_i`, writes and pops.
- R8: A write and a pop accepted in the same cycle leave the occupancy unchanged. A pop while no word is stored is ignored.
- R9: All status bits are registered. They show the occupancy that results from the same rising edge that accepts the write, pop or clear.
- R10: `avail_o` is 1 exactly when at least one word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreset_i | input | 1 | Synchronous master-reset pulse: discards contents and clears the flags |
| clear_i | input | 1 | Synchronous queue-clear command |
| irq_sel_i | input | 1 | Flag source select: 0 selects empty, 1 selects full |
| wr_en_i | input | 1 | One-cycle write request |
| wr_data_i | input | 32 | Word to store |
| pop_i | input | 1 | One-cycle pop request from the serializer |
| ser_busy_i | input | 1 | Serializer is still sending the last word it popped |
| head_o | output | 32 | Oldest stored word (combinational) |
| avail_o | output | 1 | At least one word is stored |
| empty_o | output | 1 | Empty status bit |
| half_o | output | 1 | Half-full status bit |
| full_o | output | 1 | Full status bit |
| flag_o | output | 1 | Selectable interrupt flag |

## Verification
The bench drives a table of push and pop bursts through the queue. The bursts take the occupancy across the 16-word threshold in both directions, fill it to 32, and then write into the full queue. Each burst checks the half and full bits and the order of the popped words, which separates threshold errors from pointer errors. The busy and select inputs change between bursts, so the bench can tell a flag that tracks only the count apart from one that also honours the serializer's busy state and the select input. Directed tests then cover same-cycle push with pop, a pop while empty, the clear command and the master reset. Each of these is followed by a fresh write, so the bench can confirm that the pointers stayed consistent.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int TXQ_DEPTH = 32;
    localparam int TXQ_WIDTH = 32;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
        logic irq;
    } txq_flags_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // one register row per entry, each with its own write decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk_i) begin
            if (we_i && (waddr_i == AW'(g))) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic          wr_i,
    input  logic          pop_i,
    output logic          push_ok_o,
    output logic [AW-1:0] wr_ptr_o,
    output logic [AW-1:0] rd_ptr_o,
    output logic [CW-1:0] cnt_q_o,
    output logic [CW-1:0] cnt_d_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = wr_i && (st_q.cnt != FULL_CNT) && !flush_i;
        pop_ok  = pop_i && (st_q.cnt != '0) && !flush_i;
        if (push_ok) begin
            st_d.wr = (st_q.wr == LAST_IDX) ? '0 : st_q.wr + AW'(1);
        end
        if (pop_ok) begin
            st_d.rd = (st_q.rd == LAST_IDX) ? '0 : st_q.rd + AW'(1);
        end
        unique case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_ok_o = push_ok;
    assign wr_ptr_o  = st_q.wr;
    assign rd_ptr_o  = st_q.rd;
    assign cnt_q_o   = st_q.cnt;
    assign cnt_d_o   = st_d.cnt;

    AST_FULL_DROPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == FULL_CNT && wr_i && !pop_i && !flush_i) |=> (st_q.cnt == FULL_CNT && $stable(st_q.wr))); // R2
    AST_PUSH_POP_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && pop_i && !flush_i && st_q.cnt != '0 && st_q.cnt != FULL_CNT) |=> $stable(st_q.cnt)); // R8
    AST_POP_EMPTY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == '0 && pop_i && !wr_i) |=> (st_q.cnt == '0 && $stable(st_q.rd))); // R8
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                mreset_i,
    input  logic [CW-1:0]       cnt_d_i,
    input  logic                busy_i,
    input  logic                sel_i,
    output txq_pkg::txq_flags_t flags_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(HALF);

    txq_pkg::txq_flags_t flags_d, flags_q;

    always_comb begin
        flags_d.empty = (cnt_d_i == '0) && !busy_i;
        flags_d.half  = (cnt_d_i >= HALF_CNT);
        flags_d.full  = (cnt_d_i == FULL_CNT);
        flags_d.irq   = sel_i ? flags_d.full : flags_d.empty;
        if (mreset_i) begin
            flags_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_q.full |-> flags_q.half); // R3
    AST_MRESET_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mreset_i |=> (flags_q == '0)); // R7
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DEPTH = txq_pkg::TXQ_DEPTH,
    parameter int WIDTH = txq_pkg::TXQ_WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mreset_i,
    input  logic             clear_i,
    input  logic             irq_sel_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             pop_i,
    input  logic             ser_busy_i,
    output logic [WIDTH-1:0] head_o,
    output logic             avail_o,
    output logic             empty_o,
    output logic             half_o,
    output logic             full_o,
    output logic             flag_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          push_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q, cnt_d;
    txq_pkg::txq_flags_t flags;

    txq_ptrs #(.DEPTH(DEPTH)) ptrs_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flush_i  (clear_i | mreset_i),
        .wr_i     (wr_en_i),
        .pop_i    (pop_i),
        .push_ok_o(push_ok),
        .wr_ptr_o (wr_ptr),
        .rd_ptr_o (rd_ptr),
        .cnt_q_o  (cnt_q),
        .cnt_d_o  (cnt_d)
    );

    txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk_i  (clk_i),
        .we_i   (push_ok),
        .waddr_i(wr_ptr),
        .wdata_i(wr_data_i),
        .raddr_i(rd_ptr),
        .rdata_o(head_o)
    );

    txq_flags #(.DEPTH(DEPTH)) flags_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mreset_i(mreset_i),
        .cnt_d_i (cnt_d),
        .busy_i  (ser_busy_i),
        .sel_i   (irq_sel_i),
        .flags_o (flags)
    );

    assign avail_o = (cnt_q != '0);
    assign empty_o = flags.empty;
    assign half_o  = flags.half;
    assign full_o  = flags.full;
    assign flag_o  = flags.irq;

    AST_EMPTY_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o |-> !avail_o); // R4
    AST_FLAG_FOLLOWS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (flag_o == ($past(irq_sel_i) ? full_o : empty_o))); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !avail_o); // R6
endmodule

// File: tb/txq_fifo_tb.sv
module txq_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreset = 1'b0, clear = 1'b0, sel = 1'b0;
    logic        wr_en = 1'b0, pop = 1'b0, busy = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] head;
    logic        avail, empty, half, full, flag;

    int errors = 0;
    int checks = 0;
    int dseq   = 0;
    logic [31:0] mq [$];

    always #10 clk = ~clk;  // 50 MHz

    txq_fifo dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mreset_i(mreset), .clear_i(clear),
        .irq_sel_i(sel), .wr_en_i(wr_en), .wr_data_i(wr_data), .pop_i(pop),
        .ser_busy_i(busy), .head_o(head), .avail_o(avail), .empty_o(empty),
        .half_o(half), .full_o(full), .flag_o(flag)
    );

    typedef struct packed {
        logic [7:0] npush;
        logic [7:0] npop;
        logic       busy;
        logic       sel;
        logic [7:0] lvl;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'd5,  8'd0,  1'b0, 1'b0, 8'd5},
        '{8'd11, 8'd0,  1'b1, 1'b1, 8'd16},
        '{8'd0,  8'd1,  1'b0, 1'b0, 8'd15},
        '{8'd17, 8'd0,  1'b0, 1'b1, 8'd32},
        '{8'd3,  8'd0,  1'b0, 1'b1, 8'd32},
        '{8'd0,  8'd32, 1'b1, 1'b0, 8'd0},
        '{8'd0,  8'd0,  1'b0, 1'b0, 8'd0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] next_word();
        dseq++;
        return 32'h5A00_0000 ^ (dseq * 32'h0101_0103);
    endfunction

    task automatic push_word(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (mq.size() < 32) mq.push_back(d);
    endtask

    task automatic pop_word(input string tag);
        if (mq.size() > 0) chk(tag, head, mq[0]);
        pop = 1'b1;
        @(posedge clk); @(negedge clk);
        pop = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(); tick();
        // reset state (R4, R5, R10)
        chk("R4 reset empty", empty, 1);
        chk("R3 reset half", half, 0);
        chk("R2 reset full", full, 0);
        chk("R5 reset flag", flag, 1);
        chk("R10 reset avail", avail, 0);

        // table walk: R1 R2 R3 R4 R5 R10
        foreach (VECS[i]) begin
            for (int k = 0; k < int'(VECS[i].npush); k++) push_word(next_word());
            for (int k = 0; k < int'(VECS[i].npop); k++) pop_word("R1 order");
            busy = VECS[i].busy; sel = VECS[i].sel;
            tick();
            chk("R2 level", mq.size(), VECS[i].lvl);
            chk("R3 half", half, VECS[i].lvl >= 16);
            chk("R2 full", full, VECS[i].lvl == 32);
            chk("R4 empty", empty, (VECS[i].lvl == 0) && !VECS[i].busy);
            chk("R10 avail", avail, VECS[i].lvl != 0);
            chk("R5 flag", flag, VECS[i].sel ? (VECS[i].lvl == 32)
                                             : ((VECS[i].lvl == 0) && !VECS[i].busy));
        end
        busy = 1'b0; sel = 1'b0;

        // R9: flag changes at the edge that accepts the 16th word
        for (int k = 0; k < 15; k++) push_word(next_word());
        chk("R9 half at 15", half, 0);
        push_word(next_word());
        chk("R9 half at 16", half, 1);
        pop_word("R1 order");
        chk("R9 half back at 15", half, 0);

        // R6: clear empties, pointers stay consistent
        clear = 1'b1; tick(); clear = 1'b0;
        mq.delete();
        chk("R6 avail after clear", avail, 0);
        chk("R6 empty after clear", empty, 1);
        chk("R6 half after clear", half, 0);
        push_word(32'hC1EA_0001);
        chk("R6 head after clear", head, 32'hC1EA_0001);
        pop_word("R6 order");

        // R8: simultaneous push and pop, then pop on empty
        push_word(32'hAAAA_0001);
        chk("R8 head A", head, 32'hAAAA_0001);
        wr_en = 1'b1; wr_data = 32'hBBBB_0002; pop = 1'b1;
        tick();
        wr_en = 1'b0; pop = 1'b0;
        void'(mq.pop_front()); mq.push_back(32'hBBBB_0002);
        chk("R8 head B", head, 32'hBBBB_0002);
        chk("R8 avail one left", avail, 1);
        pop_word("R8 order");
        chk("R8 drained", avail, 0);
        pop = 1'b1; tick(); pop = 1'b0;
        chk("R8 pop on empty", avail, 0);
        push_word(32'hCCCC_0003);
        chk("R8 head after empty pop", head, 32'hCCCC_0003);
        pop_word("R8 order");
        chk("R8 single pop drains", avail, 0);

        // R4: busy serializer holds empty low
        busy = 1'b1; tick();
        chk("R4 empty held by busy", empty, 0);
        chk("R5 flag held by busy", flag, 0);
        busy = 1'b0; tick();
        chk("R4 empty after busy", empty, 1);

        // R7: master reset from full, flag selected to full
        sel = 1'b1;
        for (int k = 0; k < 32; k++) push_word(next_word());
        push_word(32'hDEAD_BEEF);  // R2 dropped
        chk("R5 flag on full", flag, 1);
        chk("R2 head unchanged by drop", head, mq[0]);
        mreset = 1'b1; tick(); mreset = 1'b0;
        mq.delete();
        chk("R7 full cleared", full, 0);
        chk("R7 half cleared", half, 0);
        chk("R7 empty forced low", empty, 0);
        chk("R7 flag cleared", flag, 0);
        chk("R7 avail cleared", avail, 0);
        tick();
        chk("R7 empty recovers", empty, 1);
        chk("R7 flag tracks full", flag, 0);
        sel = 1'b0; tick();
        chk("R5 flag tracks empty", flag, 1);

        // R7 priority over a write in the same cycle
        wr_en = 1'b1; wr_data = 32'h1234_5678; mreset = 1'b1;
        tick();
        wr_en = 1'b0; mreset = 1'b0;
        chk("R7 write ignored under mreset", avail, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule